// File: doc/BRIEF.md
# Synchronous Shared-Bus FIFO Bridge

This block is the FPGA-side master for an external device that exposes a synchronous 8-bit parallel FIFO port. A single data bus carries bytes in both directions. The device reports two active-low flags: one says it holds bytes for the FPGA to read, the other says it has room for bytes the FPGA wants to write. The bridge drives an active-low output-enable, an active-low read strobe and an active-low write strobe, all registered to the interface clock. On every clock edge where a flag and its matching strobe are both low, exactly one byte moves.

Toward the user logic the bridge offers a receive stream (`rx_valid`/`rx_data`, with `rx_ready` as a pause request) and a transmit stream (`tx_valid`/`tx_ready`/`tx_data`). A small state machine chooses a direction, raises output-enable one cycle ahead of the read strobe, and leaves the bus undriven for at least one cycle whenever the direction changes. Bursts in each direction are capped at `BURST` bytes, and priority alternates whenever both directions want the bus.

The bus is split into `bus_din`, `bus_dout` and a drive enable `bus_drive`, with the tri-state buffer placed at the pad.

Top module: `sfb_bridge`

## Requirements
- R1: `rd_stb_n` is low only in a cycle that follows an edge where `rx_avail_n` was sampled low. `rx_valid` is high for one cycle right after each edge where `rx_avail_n` and `rd_stb_n` were both low, with `rx_data` equal to `bus_din` at that edge. In every other cycle `rx_valid` is low.
- R2: `oe_n` is low in the cycle before every falling edge of `rd_stb_n`, and it stays low in every cycle where `rd_stb_n` is low.
- R3: `wr_stb_n` is low only in a cycle that follows an edge where `tx_space_n` was sampled low.
- R4: Bytes accepted on the transmit stream (an edge with `tx_valid` and `tx_ready` both high) appear on `bus_dout` in acceptance order. Each byte is taken on exactly one edge where `wr_stb_n` and `tx_space_n` are both low. A byte whose strobe edge sees `tx_space_n` high is held and sent again later, before any newer byte.
- R5: `rd_stb_n` and `wr_stb_n` are never low together, and `oe_n` is high whenever `bus_drive` is high.
- R6: `bus_drive` rises only after two consecutive cycles with `oe_n` high. `oe_n` falls only after a cycle with `bus_drive` low.
- R7: A run of consecutive cycles with a strobe low never exceeds `BURST` cycles.
- R8: When both directions are possible and there is no other limit, read and write bursts of exactly `BURST` bytes alternate. The first burst after reset is a read.
- R9: `rd_stb_n` is high in every cycle that follows an edge where `rx_ready` was low.
- R10: During reset and in the first cycle after it, `rd_stb_n`, `wr_stb_n` and `oe_n` are high, and `bus_drive`, `rx_valid` and `tx_ready` are low.
- R11: If `rx_avail_n` is high at an edge during a read burst, no byte is delivered for that edge and `rd_stb_n` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_avail_n | input | 1 | Low when the device holds bytes to read |
| tx_space_n | input | 1 | Low when the device can take bytes |
| bus_din | input | DW | Data bus as seen at the pad |
| bus_dout | output | DW | Byte the FPGA presents when driving |
| bus_drive | output | 1 | High when the FPGA drives the bus |
| oe_n | output | 1 | Active-low request for the device to drive the bus |
| rd_stb_n | output | 1 | Active-low read strobe |
| wr_stb_n | output | 1 | Active-low write strobe |
| rx_valid | output | 1 | Received byte present on rx_data |
| rx_data | output | DW | Received byte |
| rx_ready | input | 1 | Low pauses further reads |
| tx_valid | input | 1 | User byte offered |
| tx_ready | output | 1 | Bridge takes the offered byte at this edge |
| tx_data | input | DW | User byte to send |

## Verification
The hardest case to reach is a byte that has been strobed onto the bus but refused because `tx_space_n` rose at that edge. The byte must then be held across a turnaround and possibly a whole read burst, and still go out ahead of newer bytes. The stimulus gets there by sweeping several arithmetic flag patterns whose periods do not line up with the burst length. This makes the space flag rise at every offset inside write bursts while read requests compete, and a byte-exact model of the device checks the order. A saturated phase, with both flags held low, pins down the exact burst length and the alternation of priority.

// File: rtl/sfb_pkg.sv
`timescale 1ns/1ps
// Shared types for the shared-bus FIFO bridge.
package sfb_pkg;
    // Controller states: idle, output-enable lead, read burst, write burst, bus release.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_OE = 3'd1,
        ST_RD    = 3'd2,
        ST_WR    = 3'd3,
        ST_TURN  = 3'd4
    } sfb_state_e;
endpackage

// File: rtl/sfb_arb.sv
`timescale 1ns/1ps
// Direction arbiter.
// Grants one direction per idle decision. The direction granted last loses
// priority to the other, so contention alternates. Reset favours reading.
// Assumes arb_en is high only while the controller is idle.
module sfb_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic arb_en,
    input  logic req_rd,
    input  logic req_wr,
    output logic gnt_rd,
    output logic gnt_wr
);
    logic rd_first_q;

    // Combinational grant from the requests and the current priority.
    always_comb begin
        gnt_rd = arb_en && req_rd && (rd_first_q || !req_wr);
        gnt_wr = arb_en && req_wr && (!rd_first_q || !req_rd);
    end

    // Hand priority to the direction that was not just served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_first_q <= 1'b1;
        end else if (gnt_rd) begin
            rd_first_q <= 1'b0;
        end else if (gnt_wr) begin
            rd_first_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sfb_rd_path.sv
`timescale 1ns/1ps
// Receive path.
// Captures a byte on each edge where the read strobe and the device flag are
// both low, and emits it as a one-cycle pulse. It also counts the bytes of the
// current burst and says whether the strobe may stay low for another cycle.
// Assumes the strobe is low only while the controller is in its read state.
module sfb_rd_path #(
    parameter int DW    = 8,
    parameter int BURST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_rd,
    input  logic          strobe_n,
    input  logic          flag_n,
    input  logic          user_ready,
    input  logic [DW-1:0] bus_din,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          keep_going
);
    localparam int CNT_W = $clog2(BURST + 1);

    logic             xfer;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_x;

    // Transfer detect and the decision to keep the strobe low.
    always_comb begin
        xfer       = !strobe_n && !flag_n;
        cnt_x      = cnt_q + CNT_W'(xfer);
        keep_going = !flag_n && user_ready && (cnt_x < CNT_W'(BURST));
    end

    // Burst byte counter, cleared outside the read state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= in_rd ? cnt_x : '0;
        end
    end

    // Capture the bus byte and raise valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= xfer;
            if (xfer) begin
                rx_data <= bus_din;
            end
        end
    end
endmodule

// File: rtl/sfb_wr_path.sv
`timescale 1ns/1ps
// Transmit path.
// Holds one byte for the bus. The byte stays in place until an edge where
// the strobe and the device flag are both low takes it, so a refused byte is
// retried later. Loads from the user stream only when the slot is free and
// the burst has room. Assumes the strobe is low only in the write state.
module sfb_wr_path #(
    parameter int DW    = 8,
    parameter int BURST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_wr,
    input  logic          strobe_n,
    input  logic          flag_n,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic          tx_ready,
    output logic          pend,
    output logic [DW-1:0] data_q,
    output logic          keep_going
);
    localparam int CNT_W = $clog2(BURST + 1);

    logic             xfer;
    logic             pend_after;
    logic             load;
    logic             pend_n;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_x;

    // Slot bookkeeping for this edge and the decision to keep strobing.
    always_comb begin
        xfer       = !strobe_n && !flag_n;
        pend_after = pend && !xfer;
        cnt_x      = cnt_q + CNT_W'(xfer);
        tx_ready   = in_wr && !pend_after && (cnt_x < CNT_W'(BURST));
        load       = tx_valid && tx_ready;
        pend_n     = pend_after || load;
        keep_going = pend_n && !flag_n;
    end

    // Slot flag and burst counter; the counter clears outside the write state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            cnt_q <= '0;
        end else begin
            pend  <= pend_n;
            cnt_q <= in_wr ? cnt_x : '0;
        end
    end

    // Slot data; it changes only when a new byte is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= tx_data;
        end
    end
endmodule

// File: rtl/sfb_bridge.sv
`timescale 1ns/1ps
// Shared-bus synchronous FIFO bridge, top level.
// Sequences the single bidirectional bus between read and write bursts.
// Output-enable comes one cycle before the read strobe. The bus is released
// for a turnaround cycle after every burst. All device-facing outputs are
// registered. Assumes the device samples strobes and flags on the same edge
// as this block, and that the tri-state buffer lives at the pad.
module sfb_bridge #(
    parameter int DW    = 8,
    parameter int BURST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_avail_n,
    input  logic          tx_space_n,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_drive,
    output logic          oe_n,
    output logic          rd_stb_n,
    output logic          wr_stb_n,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    input  logic          rx_ready,
    input  logic          tx_valid,
    output logic          tx_ready,
    input  logic [DW-1:0] tx_data
);
    import sfb_pkg::*;

    sfb_state_e state_q;
    sfb_state_e state_n;
    logic       gnt_rd;
    logic       gnt_wr;
    logic       req_rd;
    logic       req_wr;
    logic       rd_keep;
    logic       wr_keep;
    logic       wr_pend;

    // Requests seen by the arbiter while idle.
    always_comb begin
        req_rd = !rx_avail_n && rx_ready;
        req_wr = !tx_space_n && (wr_pend || tx_valid);
    end

    sfb_arb u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .arb_en (state_q == ST_IDLE),
        .req_rd (req_rd),
        .req_wr (req_wr),
        .gnt_rd (gnt_rd),
        .gnt_wr (gnt_wr)
    );

    sfb_rd_path #(.DW(DW), .BURST(BURST)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_rd      (state_q == ST_RD),
        .strobe_n   (rd_stb_n),
        .flag_n     (rx_avail_n),
        .user_ready (rx_ready),
        .bus_din    (bus_din),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .keep_going (rd_keep)
    );

    sfb_wr_path #(.DW(DW), .BURST(BURST)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_wr      (state_q == ST_WR),
        .strobe_n   (wr_stb_n),
        .flag_n     (tx_space_n),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_ready   (tx_ready),
        .pend       (wr_pend),
        .data_q     (bus_dout),
        .keep_going (wr_keep)
    );

    // Next-state selection.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (gnt_rd) begin
                    state_n = ST_RD_OE;
                end else if (gnt_wr) begin
                    state_n = ST_WR;
                end
            end
            ST_RD_OE: state_n = rd_keep ? ST_RD : ST_TURN;
            ST_RD:    state_n = rd_keep ? ST_RD : ST_TURN;
            ST_WR:    state_n = wr_keep ? ST_WR : ST_TURN;
            ST_TURN:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // State register and registered device-side controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rd_stb_n  <= 1'b1;
            wr_stb_n  <= 1'b1;
            oe_n      <= 1'b1;
            bus_drive <= 1'b0;
        end else begin
            state_q   <= state_n;
            rd_stb_n  <= !(state_n == ST_RD);
            wr_stb_n  <= !((state_q == ST_WR) && wr_keep);
            oe_n      <= !((state_n == ST_RD_OE) || (state_n == ST_RD));
            bus_drive <= (state_n == ST_WR);
        end
    end
endmodule

// File: rtl/sfb_bridge_chk.sv
`timescale 1ns/1ps
// Protocol checker for the bridge, attached with bind. It only observes.
module sfb_bridge_chk #(
    parameter int DW    = 8,
    parameter int BURST = 4
) (
    input logic clk,
    input logic rst_n,
    input logic rx_avail_n,
    input logic tx_space_n,
    input logic bus_drive,
    input logic oe_n,
    input logic rd_stb_n,
    input logic wr_stb_n,
    input logic rx_valid,
    input logic rx_ready
);
    localparam int RUN_W = $clog2(BURST + 2) + 1;

    logic [RUN_W-1:0] rd_run_q;
    logic [RUN_W-1:0] wr_run_q;

    // Length of the current run of low strobe cycles, per direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_run_q <= '0;
            wr_run_q <= '0;
        end else begin
            rd_run_q <= rd_stb_n ? '0 : rd_run_q + 1'b1;
            wr_run_q <= wr_stb_n ? '0 : wr_run_q + 1'b1;
        end
    end

    AST_RD_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_n |-> $past(!rx_avail_n)); // R1
    AST_VALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(!rd_stb_n && !rx_avail_n)); // R1
    AST_OE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_stb_n) |-> $past(!oe_n)); // R2
    AST_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_n |-> !oe_n); // R2
    AST_WR_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_n |-> $past(!tx_space_n)); // R3
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_stb_n && !wr_stb_n)); // R5
    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> oe_n); // R5
    AST_DRIVE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_drive) |-> ($past(oe_n) && $past(oe_n, 2))); // R6
    AST_OE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> $past(!bus_drive)); // R6
    AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_run_q <= RUN_W'(BURST)) && (wr_run_q <= RUN_W'(BURST))); // R7
    AST_RDY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_n |-> $past(rx_ready)); // R9
endmodule

bind sfb_bridge sfb_bridge_chk #(.DW(DW), .BURST(BURST)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_avail_n (rx_avail_n),
    .tx_space_n (tx_space_n),
    .bus_drive  (bus_drive),
    .oe_n       (oe_n),
    .rd_stb_n   (rd_stb_n),
    .wr_stb_n   (wr_stb_n),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready)
);

// File: tb/sfb_bridge_tb.sv
`timescale 1ns/1ps
// Bench: a byte-exact model of the device side plus arithmetic flag sweeps.
module sfb_bridge_tb;
    localparam int DW    = 8;
    localparam int BURST = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_avail_n = 1'b1;
    logic          tx_space_n = 1'b1;
    logic [DW-1:0] bus_din;
    logic [DW-1:0] bus_dout;
    logic          bus_drive;
    logic          oe_n;
    logic          rd_stb_n;
    logic          wr_stb_n;
    logic          rx_valid;
    logic [DW-1:0] rx_data;
    logic          rx_ready = 1'b0;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic [DW-1:0] tx_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int rd_idx = 0;
    int tx_uidx = 0;
    int sink_idx = 0;
    bit exp_rx = 0;
    bit exp_load = 0;
    bit last_rx_flag = 1;
    bit last_tx_flag = 1;
    bit last_rdy = 0;
    bit prev_oe_n = 1;
    bit prev2_oe_n = 1;
    bit prev_drive = 0;
    int rd_run = 0;
    int wr_run = 0;
    bit sat = 0;
    bit sat_expect_rd = 1;

    always #2 clk = ~clk;

    sfb_bridge #(.DW(DW), .BURST(BURST)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_avail_n (rx_avail_n),
        .tx_space_n (tx_space_n),
        .bus_din    (bus_din),
        .bus_dout   (bus_dout),
        .bus_drive  (bus_drive),
        .oe_n       (oe_n),
        .rd_stb_n   (rd_stb_n),
        .wr_stb_n   (wr_stb_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_data    (tx_data)
    );

    function automatic logic [DW-1:0] src_byte(input int i);
        return DW'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [DW-1:0] usr_byte(input int i);
        return DW'(((i * 53 + 5) ^ 90) & 255);
    endfunction

    // The device presents the next byte of its queue on the bus.
    assign bus_din = src_byte(rd_idx);

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // One interface cycle: check last edge, drive inputs, predict next edge.
    task automatic cyc(input bit f_rx_n, input bit f_tx_n, input bit rdy, input bit vld);
        @(negedge clk);
        if (exp_rx) begin
            chk(rx_valid && (rx_data == src_byte(rd_idx)), "R1 received byte", int'(rx_data), int'(src_byte(rd_idx)));
            rd_idx++;
        end else begin
            chk(!rx_valid, "R11 no byte without transfer", int'(rx_valid), 0);
        end
        if (exp_load) tx_uidx++;
        if (!rd_stb_n) begin
            chk(!last_rx_flag, "R1 read strobe after flag low", int'(last_rx_flag), 0);
            chk(last_rdy, "R9 read strobe after ready", int'(last_rdy), 1);
            chk(!prev_oe_n && !oe_n, "R2 oe lead", int'(prev_oe_n), 0);
        end
        if (!wr_stb_n) chk(!last_tx_flag, "R3 write strobe after flag low", int'(last_tx_flag), 0);
        chk(!(!rd_stb_n && !wr_stb_n) && !(bus_drive && !oe_n), "R5 exclusive bus use",
            int'({rd_stb_n, wr_stb_n, bus_drive, oe_n}), 0);
        if (bus_drive && !prev_drive)
            chk(prev_oe_n && prev2_oe_n, "R6 gap before drive", int'({prev2_oe_n, prev_oe_n}), 3);
        if (!oe_n && prev_oe_n)
            chk(!prev_drive, "R6 gap before oe", int'(prev_drive), 0);
        if (!rd_stb_n) rd_run++;
        else if (rd_run > 0) begin
            chk(rd_run <= BURST, "R7 read run cap", rd_run, BURST);
            if (sat) begin
                chk(rd_run == BURST, "R8 full read burst", rd_run, BURST);
                chk(sat_expect_rd, "R8 read turn", 1, int'(sat_expect_rd));
                sat_expect_rd = 0;
            end
            rd_run = 0;
        end
        if (!wr_stb_n) wr_run++;
        else if (wr_run > 0) begin
            chk(wr_run <= BURST, "R7 write run cap", wr_run, BURST);
            if (sat) begin
                chk(wr_run == BURST, "R8 full write burst", wr_run, BURST);
                chk(!sat_expect_rd, "R8 write turn", 0, int'(sat_expect_rd));
                sat_expect_rd = 1;
            end
            wr_run = 0;
        end
        prev2_oe_n = prev_oe_n;
        prev_oe_n  = oe_n;
        prev_drive = bus_drive;
        rx_avail_n = f_rx_n;
        tx_space_n = f_tx_n;
        rx_ready   = rdy;
        tx_valid   = vld;
        tx_data    = usr_byte(tx_uidx);
        #1;
        exp_rx   = !rd_stb_n && !rx_avail_n;
        exp_load = tx_valid && tx_ready;
        if (!wr_stb_n && !tx_space_n) begin
            chk(bus_drive && (bus_dout == usr_byte(sink_idx)), "R4 written byte order",
                int'(bus_dout), int'(usr_byte(sink_idx)));
            sink_idx++;
        end
        last_rx_flag = rx_avail_n;
        last_tx_flag = tx_space_n;
        last_rdy     = rx_ready;
    endtask

    // Flush, reset, and check the idle outputs during and after reset.
    task automatic do_reset();
        cyc(1, 1, 0, 0);
        cyc(1, 1, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        rx_avail_n = 1'b1;
        tx_space_n = 1'b1;
        tx_valid = 1'b0;
        rx_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(rd_stb_n && wr_stb_n && oe_n && !bus_drive && !rx_valid && !tx_ready,
            "R10 reset outputs", int'({rd_stb_n, wr_stb_n, oe_n, bus_drive, rx_valid, tx_ready}), 'h38);
        rst_n = 1'b1;
        exp_rx = 0;
        exp_load = 0;
        sink_idx = tx_uidx;
        rd_run = 0;
        wr_run = 0;
        last_rx_flag = 1;
        last_tx_flag = 1;
        last_rdy = 0;
        prev_oe_n = 1;
        prev2_oe_n = 1;
        prev_drive = 0;
        @(negedge clk);
        chk(rd_stb_n && wr_stb_n && oe_n && !bus_drive && !rx_valid && !tx_ready,
            "R10 first cycle after reset", int'({rd_stb_n, wr_stb_n, oe_n, bus_drive, rx_valid, tx_ready}), 'h38);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        // Sweeps over flag and stream patterns with unrelated periods.
        for (int m = 0; m < 8; m++) begin
            do_reset();
            for (int c = 0; c < 400; c++) begin
                cyc(((c + m) % (m + 3) == 0) || (((c / 16) % 5) == (m % 5)),
                    ((c * (m + 1) / 3) % 5) == 4,
                    (c % (m + 4)) != 1,
                    (c % (m + 5)) != 2);
            end
        end
        // Saturated phase: both directions always possible.
        do_reset();
        sat = 1;
        sat_expect_rd = 1;
        for (int c = 0; c < 120; c++) cyc(0, 0, 1, 1);
        sat = 0;
        do_reset();
        finish_run();
    end
endmodule